// File: doc/BRIEF.md
# Video memory data port controller

This block connects a slow CPU bus to video memory in a graphics clock domain that runs at exactly three times the CPU clock. The CPU reaches a small window of registers through an active-low chip select, a 3-bit register index, a read/write strobe and an 8-bit data bus. One CPU access holds chip select low for three or more fast cycles. The block turns each access into one action only: one memory transfer and one address step.

Three registers are decoded. A control register holds the increment-select bit. A video address register is loaded by two byte writes. A data port writes a byte to video memory, or returns a byte from it through a one-deep read buffer. After each data port access the address steps forward by 1 or by 32. The memory itself sits outside the block. It is read combinationally from the address output and is written on the clock edge that ends a cycle with the write enable high.

Top module: `vram_port_ctrl`

## Requirements
- R1: Reset clears the address to 0, the increment select to "step 1" and the byte-select toggle to "high byte next", and drives `cpu_rdata` to 0 and `vram_we` low.
- R2: An access is accepted only on the first cycle in which `cpu_cs_n` is low after a cycle in which it was high. Chip select held low for any number of further cycles causes no further memory transfer and no further address change.
- R3: A write (`cpu_rw`=0) to index 7 raises `vram_we` for exactly one cycle. That is the accepting cycle. In it `vram_addr` holds the pre-increment address and `vram_wdata` equals `cpu_wdata`.
- R4: With bit 2 of the last byte written to index 0 equal to 0, every data port access advances the address by 1.
- R5: With bit 2 of the last byte written to index 0 equal to 1, every data port access advances the address by 32.
- R6: The address is 14 bits wide and wraps modulo 16384 when it advances.
- R7: Writes to index 6 alternate. The first write after reset loads address bits 13:8 from data bits 5:0, and data bits 7:6 are ignored. The next write loads address bits 7:0. Then the alternation repeats.
- R8: A read (`cpu_rw`=1) of index 7 returns the byte that the buffer held before the access. The buffer then takes the memory byte at the pre-increment address, and the address advances as it does for a write. From the cycle after the accepting cycle, `cpu_rdata` stays stable until the next accepted access.
- R9: A read of any index other than 7 returns 0. A write to an index other than 0, 6 or 7 changes neither the address nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, three times the CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs_n | input | 1 | Active-low chip select for the register window |
| cpu_idx | input | 3 | Register index: 0 control, 6 address, 7 data |
| cpu_rw | input | 1 | 1 read, 0 write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| vram_addr | output | 14 | Current video memory address |
| vram_wdata | output | 8 | Video memory write data |
| vram_we | output | 1 | Video memory write enable, one cycle per write access |
| vram_rdata | input | 8 | Video memory read data at `vram_addr` |

## Verification
The write enable and write data are combinational in the accepting cycle, so memory changes on the first rising edge after chip select falls. The address step, register loads and the new `cpu_rdata` show up after that same edge. The bench drives its inputs on falling edges. It samples the address, the returned byte and the count of write pulses only at the falling edge that ends the access. By then the accepting edge and two or more held cycles have passed. A stray second step or second write would therefore already be visible when the bench samples.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

   // Decoded one-cycle commands, at most one bit high per accepted access
   typedef struct packed {
      logic ctrl_wr;
      logic addr_wr;
      logic data_wr;
      logic data_rd;
      logic other_rd;
   } vrp_cmd_t;

endpackage

// File: rtl/vrp_access_detect.sv
module vrp_access_detect
   import vrp_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter int CTRL_IDX = 0,
   parameter int ADDR_IDX = 6,
   parameter int DATA_IDX = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             rw,
   output vrp_cmd_t         cmd
);

   localparam int NUM_IDX = 1 << IDX_W;

   if (CTRL_IDX >= NUM_IDX || ADDR_IDX >= NUM_IDX || DATA_IDX >= NUM_IDX) begin : g_bad_idx
      $error("register index outside the window");
   end
   if (CTRL_IDX == ADDR_IDX || CTRL_IDX == DATA_IDX || ADDR_IDX == DATA_IDX) begin : g_dup_idx
      $error("register indices must differ");
   end

   logic cs_prev_n;
   logic start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_prev_n <= 1'b1;
      else        cs_prev_n <= cs_n;
   end

   // Only the first low cycle of a select window is accepted
   assign start = cs_prev_n & ~cs_n;

   always_comb begin
      cmd          = '0;
      cmd.ctrl_wr  = start & ~rw & (idx == IDX_W'(CTRL_IDX));
      cmd.addr_wr  = start & ~rw & (idx == IDX_W'(ADDR_IDX));
      cmd.data_wr  = start & ~rw & (idx == IDX_W'(DATA_IDX));
      cmd.data_rd  = start &  rw & (idx == IDX_W'(DATA_IDX));
      cmd.other_rd = start &  rw & (idx != IDX_W'(DATA_IDX));
   end

endmodule

// File: rtl/vrp_addr_reg.sv
module vrp_addr_reg
   import vrp_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int DATA_W    = 8,
   parameter int INC_BIT   = 2,
   parameter int WIDE_STEP = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  vrp_cmd_t          cmd,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] addr,
   output logic              inc_wide
);

   localparam int HI_W = ADDR_W - DATA_W;
   localparam logic [ADDR_W-1:0] STEP_ONE  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_WIDE = ADDR_W'(WIDE_STEP);

   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_w
      $error("address must span more than one and at most two data bytes");
   end
   if (INC_BIT >= DATA_W) begin : g_bad_bit
      $error("increment bit outside data byte");
   end
   if (WIDE_STEP < 1 || WIDE_STEP >= (1 << ADDR_W)) begin : g_bad_step
      $error("wide step out of range");
   end

   logic hi_next_n;   // 0: next index-6 write loads the high part
   logic advance;
   logic [ADDR_W-1:0] step;

   assign advance = cmd.data_wr | cmd.data_rd;
   assign step    = inc_wide ? STEP_WIDE : STEP_ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr      <= '0;
         hi_next_n <= 1'b0;
         inc_wide  <= 1'b0;
      end else begin
         if (cmd.ctrl_wr) inc_wide <= wdata[INC_BIT];
         if (cmd.addr_wr) begin
            hi_next_n <= ~hi_next_n;
            if (!hi_next_n) addr[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
            else            addr[DATA_W-1:0]      <= wdata;
         end else if (advance) begin
            addr <= addr + step;
         end
      end
   end

endmodule

// File: rtl/vrp_read_buf.sv
module vrp_read_buf
   import vrp_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit READ_BUFFERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  vrp_cmd_t          cmd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rdata
);

   if (READ_BUFFERED) begin : g_buffered
      logic [DATA_W-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
            rdata  <= '0;
         end else if (cmd.data_rd) begin
            rdata  <= hold_q;
            hold_q <= mem_rdata;
         end else if (cmd.other_rd) begin
            rdata  <= '0;
         end
      end
   end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             rdata <= '0;
         else if (cmd.data_rd)   rdata <= mem_rdata;
         else if (cmd.other_rd)  rdata <= '0;
      end
   end

endmodule

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
   import vrp_pkg::*;
#(
   parameter int ADDR_W        = 14,
   parameter int DATA_W        = 8,
   parameter int IDX_W         = 3,
   parameter int CTRL_IDX      = 0,
   parameter int ADDR_IDX      = 6,
   parameter int DATA_IDX      = 7,
   parameter int INC_BIT       = 2,
   parameter int WIDE_STEP     = 32,
   parameter bit READ_BUFFERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_cs_n,
   input  logic [IDX_W-1:0]  cpu_idx,
   input  logic              cpu_rw,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [ADDR_W-1:0] vram_addr,
   output logic [DATA_W-1:0] vram_wdata,
   output logic              vram_we,
   input  logic [DATA_W-1:0] vram_rdata
);

   vrp_cmd_t cmd;
   logic     inc_wide;

   vrp_access_detect #(
      .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX), .ADDR_IDX(ADDR_IDX), .DATA_IDX(DATA_IDX)
   ) detect_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cpu_cs_n), .idx(cpu_idx), .rw(cpu_rw), .cmd(cmd)
   );

   vrp_addr_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INC_BIT(INC_BIT), .WIDE_STEP(WIDE_STEP)
   ) addr_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(cpu_wdata),
      .addr(vram_addr), .inc_wide(inc_wide)
   );

   vrp_read_buf #(
      .DATA_W(DATA_W), .READ_BUFFERED(READ_BUFFERED)
   ) rbuf_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .mem_rdata(vram_rdata), .rdata(cpu_rdata)
   );

   assign vram_we    = cmd.data_wr;
   assign vram_wdata = cpu_wdata;

endmodule

// File: rtl/vrp_chk.sv
module vrp_chk #(
   parameter int ADDR_W    = 14,
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 3,
   parameter int DATA_IDX  = 7,
   parameter int WIDE_STEP = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_cs_n,
   input logic [IDX_W-1:0]  cpu_idx,
   input logic              cpu_rw,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic [ADDR_W-1:0] vram_addr,
   input logic              vram_we,
   input logic              inc_wide
);

   localparam logic [ADDR_W-1:0] S_ONE  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] S_WIDE = ADDR_W'(WIDE_STEP);

   // R2
   first_cycle_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vram_we |-> (!cpu_cs_n && $past(cpu_cs_n)));

   // R3
   we_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vram_we |-> (!cpu_rw && cpu_idx == IDX_W'(DATA_IDX)));

   // R4 R5 R6
   data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_cs_n && $past(cpu_cs_n) && cpu_idx == IDX_W'(DATA_IDX))
      |=> (vram_addr == $past(vram_addr) + ($past(inc_wide) ? S_WIDE : S_ONE)));

   // R2
   idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_cs_n |=> $stable(vram_addr));

   // R8
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_cs_n |=> $stable(cpu_rdata));

endmodule

bind vram_port_ctrl vrp_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .DATA_IDX(DATA_IDX), .WIDE_STEP(WIDE_STEP)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_idx(cpu_idx), .cpu_rw(cpu_rw),
   .cpu_rdata(cpu_rdata), .vram_addr(vram_addr), .vram_we(vram_we), .inc_wide(inc_wide)
);

// File: tb/vram_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module vram_port_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_cs_n = 1'b1;
   logic [2:0] cpu_idx = 3'd0;
   logic       cpu_rw = 1'b1;
   logic [7:0] cpu_wdata = 8'd0;
   logic [7:0] cpu_rdata;
   logic [13:0] vram_addr;
   logic [7:0] vram_wdata;
   logic       vram_we;
   logic [7:0] vram_rdata;

   logic [7:0] mem [1024];
   int we_cnt = 0;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   vram_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_idx(cpu_idx), .cpu_rw(cpu_rw),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vram_addr(vram_addr),
      .vram_wdata(vram_wdata), .vram_we(vram_we), .vram_rdata(vram_rdata)
   );

   assign vram_rdata = mem[vram_addr[9:0]];

   always @(posedge clk) begin
      if (vram_we) begin
         mem[vram_addr[9:0]] <= vram_wdata;
         we_cnt = we_cnt + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic [2:0] idx, input logic rd, input logic [7:0] d,
                         input int hold, output logic [7:0] q);
      @(negedge clk);
      cpu_cs_n = 1'b0; cpu_idx = idx; cpu_rw = rd; cpu_wdata = d;
      repeat (hold) @(negedge clk);
      q = cpu_rdata;
      cpu_cs_n = 1'b1; cpu_rw = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] idx, input logic [7:0] d);
      logic [7:0] q;
      access(idx, 1'b0, d, 3, q);
   endtask

   task automatic set_addr(input logic [13:0] a);
      wr(3'd6, {2'b00, a[13:8]});
      wr(3'd6, a[7:0]);
   endtask

   task automatic t_reset();
      check("R1 addr", vram_addr, 0);
      check("R1 rdata", cpu_rdata, 0);
      check("R1 we", vram_we, 0);
   endtask

   task automatic t_addr_load();
      // first write after reset is the high part; bits 7:6 ignored (R7)
      wr(3'd6, 8'hFF);
      wr(3'd6, 8'h12);
      check("R7 two-byte load", vram_addr, 14'h3F12);
      // increment select is step 1 out of reset (R1)
      wr(3'd7, 8'h5A);
      check("R1 reset step", vram_addr, 14'h3F13);
      check("R3 mem", mem[10'h312], 8'h5A);
      wr(3'd6, 8'h01);
      wr(3'd6, 8'h23);
      check("R7 alternation", vram_addr, 14'h0123);
   endtask

   task automatic t_write_step1();
      int base;
      logic [7:0] q;
      wr(3'd0, 8'h00);
      set_addr(14'h0100);
      base = we_cnt;
      wr(3'd7, 8'hA5);
      check("R3 one pulse", we_cnt - base, 1);
      check("R3 data", mem[10'h100], 8'hA5);
      check("R4 step1", vram_addr, 14'h0101);
      base = we_cnt;
      access(3'd7, 1'b0, 8'h3C, 7, q);
      check("R2 long hold pulses", we_cnt - base, 1);
      check("R2 long hold addr", vram_addr, 14'h0102);
      check("R2 data", mem[10'h101], 8'h3C);
   endtask

   task automatic t_step32();
      wr(3'd0, 8'h04);
      set_addr(14'h0200);
      wr(3'd7, 8'h77);
      check("R5 step32", vram_addr, 14'h0220);
      check("R5 mem", mem[10'h200], 8'h77);
      wr(3'd0, 8'hFB);   // bit 2 clear, other bits set
      wr(3'd7, 8'h78);
      check("R4 bit2 only", vram_addr, 14'h0221);
   endtask

   task automatic t_wrap();
      wr(3'd0, 8'h00);
      set_addr(14'h3FFF);
      wr(3'd7, 8'h99);
      check("R6 wrap step1", vram_addr, 14'h0000);
      check("R6 mem", mem[10'h3FF], 8'h99);
      wr(3'd0, 8'h04);
      set_addr(14'h3FF0);
      wr(3'd7, 8'h98);
      check("R6 wrap step32", vram_addr, 14'h0010);
   endtask

   task automatic t_read();
      logic [7:0] q;
      int base;
      wr(3'd0, 8'h00);
      set_addr(14'h0040);
      wr(3'd7, 8'h11);
      wr(3'd7, 8'h22);
      wr(3'd7, 8'h33);
      set_addr(14'h0040);
      base = we_cnt;
      access(3'd7, 1'b1, 8'h00, 3, q);   // returns stale buffer, loads 0x11
      access(3'd7, 1'b1, 8'h00, 3, q);
      check("R8 buffered read 1", q, 8'h11);
      access(3'd7, 1'b1, 8'h00, 5, q);
      check("R8 buffered read 2", q, 8'h22);
      check("R8 read addr", vram_addr, 14'h0043);
      check("R8 no write", we_cnt - base, 0);
   endtask

   task automatic t_ignored();
      logic [7:0] q;
      int base;
      set_addr(14'h0155);
      base = we_cnt;
      wr(3'd3, 8'hEE);
      check("R9 other write addr", vram_addr, 14'h0155);
      check("R9 other write mem", we_cnt - base, 0);
      access(3'd2, 1'b1, 8'h00, 3, q);
      check("R9 other read data", q, 8'h00);
      check("R9 other read addr", vram_addr, 14'h0155);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_addr_load();
      t_write_step1();
      t_step32();
      t_wrap();
      t_read();
      t_ignored();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(10 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule